// File: doc/BRIEF.md
# Multi-Mode Stereo Serial Audio Receiver

This block turns a two-channel serial audio stream into parallel sample pairs for logic running on a fast system clock. The stream consists of a bit clock, a left/right frame clock, an optional word clock and one serial data line. Each channel word is twos-complement and arrives most significant bit first. All four serial inputs pass through synchronisers into the system clock domain. The block then finds the chosen bit-clock edge there and frames every word according to a 2-bit format code.

A word can be 4 to 16 bits long. When fewer bit clocks arrive than the result is wide, the unused low bits stay zero. When more arrive, the surplus bits are dropped. The bit clock may stop or run in bursts. A word is closed when the next word opens. Once the right word of a frame closes, the left/right pair appears on the outputs together with a valid pulse one system clock wide.

Top module: `stereo_serial_rx`

## Requirements
- R1: While reset is high and in the first cycle after it, `valid_o` is 0 and both sample outputs are zero.
- R2: With `mode_i` = 2'b00, a slot opens at the active bit-clock edge where `lrclk_i` differs from its value at the previous active edge. That same edge carries the MSB.
- R3: With `mode_i` = 2'b01, a slot opens at an `lrclk_i` change as in R2. The MSB is taken at the next active edge, one bit clock later.
- R4: With `mode_i` = 2'b10, the MSB is taken at the active edge 16 bit clocks after the edge that opened the slot. Bits carried before that edge are ignored.
- R5: With `mode_i` = 2'b11, a word opens at the active edge where `wclk_i` is 1 and was 0 at the previous active edge. The MSB is carried on that edge. The channel is the `lrclk_i` level at that edge, and changes of `lrclk_i` open no word in this format.
- R6: When `bclk_pol_i` = 0, inputs are sampled on rising edges of `bclk_i`. When it is 1, they are sampled on falling edges.
- R7: If a slot ends after fewer than 16 data bits, the bits received fill the result from the MSB down and the remaining low bits are 0.
- R8: Data bits after the 16th in a word are ignored.
- R9: `lrclk_i` = 1 marks the left channel and 0 the right channel. When a right word closes after a left word, exactly one `valid_o` pulse of one cycle presents both words. The outputs hold their values between pulses.
- R10: Pauses of any length in `bclk_i` between edges do not change the captured samples.
- R11: A right word that closes with no left word stored since the last pair produces no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | Framing format code (see R2 to R5) |
| bclk_pol_i | input | 1 | Bit-clock sampling edge: 0 rising, 1 falling |
| bclk_i | input | 1 | Serial bit clock, may be gated |
| lrclk_i | input | 1 | Frame clock, 1 = left channel |
| wclk_i | input | 1 | Word clock, used in format 2'b11 |
| sdata_i | input | 1 | Serial data, MSB first |
| left_o | output | SAMPLE_W | Left sample of the last pair |
| right_o | output | SAMPLE_W | Right sample of the last pair |
| valid_o | output | 1 | One-cycle pulse when a new pair is presented |

## Verification
The hardest case to reach from the ports is a right word that closes with no left word stored. A normal stream never produces it. The bench creates it by leaving reset with the frame clock already high. The first slot the block sees is then a right slot, and the bench checks that it yields no pair. The scoreboard also covers word-clock framing with the word start placed two bits after the frame-clock change. It covers slots cut short to 12 and 4 bit clocks, and bit clocks whose high and low phases vary in length from bit to bit.

// File: rtl/srx_pkg.sv
package srx_pkg;
  typedef enum logic [1:0] {
    FMT_LEFT      = 2'b00,
    FMT_LEFT_DLY  = 2'b01,
    FMT_RIGHT     = 2'b10,
    FMT_WORDCLK   = 2'b11
  } srx_fmt_e;
endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= '0;
        else     chain[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= '0;
        else     chain[s] <= chain[s-1];
      end
    end
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/srx_edge.sv
module srx_edge (
  input  logic clk,
  input  logic rst,
  input  logic pol_i,
  input  logic bclk_i,
  input  logic din_i,
  input  logic lr_i,
  input  logic wc_i,
  output logic smp_o,
  output logic din_o,
  output logic lr_o,
  output logic wc_o
);
  logic prev_r;
  logic primed_r;
  logic active;

  // An active edge is a change of the synchronised bit clock to the
  // level opposite the polarity setting.
  assign active = primed_r && (bclk_i != prev_r) && (bclk_i == !pol_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_r   <= 1'b0;
      primed_r <= 1'b0;
      smp_o    <= 1'b0;
      din_o    <= 1'b0;
      lr_o     <= 1'b0;
      wc_o     <= 1'b0;
    end else begin
      prev_r   <= bclk_i;
      primed_r <= 1'b1;
      smp_o    <= active;
      din_o    <= din_i;
      lr_o     <= lr_i;
      wc_o     <= wc_i;
    end
  end
endmodule

// File: rtl/srx_frame.sv
module srx_frame
  import srx_pkg::*;
#(
  parameter int SAMPLE_W  = 16,
  parameter int RJ_OFFSET = 16,
  parameter int POS_W     = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  srx_fmt_e            fmt_i,
  input  logic                smp_i,
  input  logic                din_i,
  input  logic                lr_i,
  input  logic                wc_i,
  output logic                word_vld_o,
  output logic                word_left_o,
  output logic [SAMPLE_W-1:0] word_o
);
  logic                primed_r;
  logic                lr_q;
  logic                wc_q;
  logic                open_r;
  logic                chan_r;
  logic [POS_W-1:0]    pos_r;
  logic [SAMPLE_W-1:0] acc_r;

  logic [POS_W-1:0]    offset;
  logic                start;
  logic [POS_W-1:0]    pos_eff;
  logic [POS_W-1:0]    pos_n;
  logic [SAMPLE_W-1:0] acc_n;

  always_comb begin
    case (fmt_i)
      FMT_LEFT_DLY: offset = POS_W'(1);
      FMT_RIGHT:    offset = POS_W'(RJ_OFFSET);
      default:      offset = '0;
    endcase
  end

  always_comb begin
    if (fmt_i == FMT_WORDCLK) start = primed_r && wc_i && !wc_q;
    else                      start = primed_r && (lr_i != lr_q);

    pos_eff = start ? '0 : pos_r;
    acc_n   = start ? '0 : acc_r;
    // Place the bit at its weight; positions past the last weight drop out.
    for (int i = 0; i < SAMPLE_W; i++) begin
      if (pos_eff == offset + POS_W'(i)) acc_n[SAMPLE_W-1-i] = din_i;
    end
    pos_n = (pos_eff == '1) ? pos_eff : pos_eff + POS_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      primed_r    <= 1'b0;
      lr_q        <= 1'b0;
      wc_q        <= 1'b0;
      open_r      <= 1'b0;
      chan_r      <= 1'b0;
      pos_r       <= '0;
      acc_r       <= '0;
      word_vld_o  <= 1'b0;
      word_left_o <= 1'b0;
      word_o      <= '0;
    end else begin
      word_vld_o <= 1'b0;
      if (smp_i) begin
        lr_q     <= lr_i;
        wc_q     <= wc_i;
        primed_r <= 1'b1;
        if (start) begin
          word_vld_o  <= open_r;
          word_left_o <= chan_r;
          word_o      <= acc_r;
          open_r      <= 1'b1;
          chan_r      <= lr_i;
        end
        if (start || open_r) begin
          acc_r <= acc_n;
          pos_r <= pos_n;
        end
      end
    end
  end
endmodule

// File: rtl/srx_pair.sv
module srx_pair #(
  parameter int SAMPLE_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                word_vld_i,
  input  logic                word_left_i,
  input  logic [SAMPLE_W-1:0] word_i,
  output logic [SAMPLE_W-1:0] left_o,
  output logic [SAMPLE_W-1:0] right_o,
  output logic                valid_o
);
  logic [SAMPLE_W-1:0] hold_r;
  logic                have_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_r  <= '0;
      have_r  <= 1'b0;
      left_o  <= '0;
      right_o <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (word_vld_i) begin
        if (word_left_i) begin
          hold_r <= word_i;
          have_r <= 1'b1;
        end else if (have_r) begin
          left_o  <= hold_r;
          right_o <= word_i;
          valid_o <= 1'b1;
          have_r  <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/stereo_serial_rx.sv
module stereo_serial_rx
  import srx_pkg::*;
#(
  parameter int SAMPLE_W    = 16,
  parameter int RJ_OFFSET   = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [1:0]          mode_i,
  input  logic                bclk_pol_i,
  input  logic                bclk_i,
  input  logic                lrclk_i,
  input  logic                wclk_i,
  input  logic                sdata_i,
  output logic [SAMPLE_W-1:0] left_o,
  output logic [SAMPLE_W-1:0] right_o,
  output logic                valid_o
);
  localparam int POS_W = $clog2(RJ_OFFSET + SAMPLE_W + 1);

  logic [3:0]          raw_s;
  logic                smp_en;
  logic                e_din;
  logic                e_lr;
  logic                e_wc;
  logic                w_vld;
  logic                w_left;
  logic [SAMPLE_W-1:0] w_data;

  srx_sync #(.W(4), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i ({bclk_i, sdata_i, lrclk_i, wclk_i}),
    .q_o (raw_s)
  );

  srx_edge u_edge (
    .clk    (clk),
    .rst    (rst),
    .pol_i  (bclk_pol_i),
    .bclk_i (raw_s[3]),
    .din_i  (raw_s[2]),
    .lr_i   (raw_s[1]),
    .wc_i   (raw_s[0]),
    .smp_o  (smp_en),
    .din_o  (e_din),
    .lr_o   (e_lr),
    .wc_o   (e_wc)
  );

  srx_frame #(.SAMPLE_W(SAMPLE_W), .RJ_OFFSET(RJ_OFFSET), .POS_W(POS_W)) u_frame (
    .clk         (clk),
    .rst         (rst),
    .fmt_i       (srx_fmt_e'(mode_i)),
    .smp_i       (smp_en),
    .din_i       (e_din),
    .lr_i        (e_lr),
    .wc_i        (e_wc),
    .word_vld_o  (w_vld),
    .word_left_o (w_left),
    .word_o      (w_data)
  );

  srx_pair #(.SAMPLE_W(SAMPLE_W)) u_pair (
    .clk         (clk),
    .rst         (rst),
    .word_vld_i  (w_vld),
    .word_left_i (w_left),
    .word_i      (w_data),
    .left_o      (left_o),
    .right_o     (right_o),
    .valid_o     (valid_o)
  );
endmodule

// File: rtl/stereo_serial_rx_chk.sv
module stereo_serial_rx_chk #(
  parameter int SAMPLE_W = 16
) (
  input logic                clk,
  input logic                rst,
  input logic                smp,
  input logic                wvld,
  input logic                wleft,
  input logic                valid_o,
  input logic [SAMPLE_W-1:0] left_o,
  input logic [SAMPLE_W-1:0] right_o
);
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!valid_o && left_o == '0 && right_o == '0));

  a_r9_single_cycle_valid: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o);

  a_r9_valid_from_right_close: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> $past(wvld && !wleft));

  a_r9_hold_between_pairs: assert property (@(posedge clk) disable iff (rst)
    !valid_o |-> ($stable(left_o) && $stable(right_o)));

  a_r10_edges_spaced: assert property (@(posedge clk) disable iff (rst)
    smp |=> !smp);
endmodule

bind stereo_serial_rx stereo_serial_rx_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .smp     (smp_en),
  .wvld    (w_vld),
  .wleft   (w_left),
  .valid_o (valid_o),
  .left_o  (left_o),
  .right_o (right_o)
);

// File: tb/stereo_serial_rx_tb.sv
module stereo_serial_rx_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  mode = 2'b00;
  logic        pol = 1'b0;
  logic        bclk = 1'b0;
  logic        lr = 1'b0;
  logic        wclk = 1'b0;
  logic        din = 1'b0;
  logic [15:0] left_o;
  logic [15:0] right_o;
  logic        valid_o;

  int    n_checks = 0;
  int    n_fail   = 0;
  bit    done     = 1'b0;
  bit    gappy    = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [31:0] exp_v;
  string       tag_v;

  always #4 clk = ~clk;

  stereo_serial_rx u_dut (
    .clk        (clk),
    .rst        (rst),
    .mode_i     (mode),
    .bclk_pol_i (pol),
    .bclk_i     (bclk),
    .lrclk_i    (lr),
    .wclk_i     (wclk),
    .sdata_i    (din),
    .left_o     (left_o),
    .right_o    (right_o),
    .valid_o    (valid_o)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: pop expected pairs as the design presents them.
  always @(negedge clk) begin
    if (!rst && valid_o) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R9/R11 unexpected pair", {left_o, right_o}, 32'h0);
      end else begin
        exp_v = exp_q.pop_front();
        tag_v = tag_q.pop_front();
        check({left_o, right_o} == exp_v, tag_v, {left_o, right_o}, exp_v);
      end
    end
  end

  task automatic send_bit(input logic l, input logic w, input logic d, input int half);
    @(negedge clk);
    bclk = pol; lr = l; wclk = w; din = d;
    repeat (half) @(negedge clk);
    bclk = ~pol;
    repeat (half) @(negedge clk);
  endtask

  task automatic send_slot(input logic chan, input logic [15:0] word, input int nbits,
                           input int wpos, output logic [15:0] expw);
    int off;
    off  = (mode == 2'b01) ? 1 : (mode == 2'b10) ? 16 : 0;
    expw = '0;
    for (int p = 0; p < nbits; p++) begin
      int   k;
      logic w;
      logic d;
      k = (mode == 2'b11) ? p - wpos : p - off;
      w = (mode == 2'b11) && (p == wpos);
      d = (k >= 0 && k < 16) ? word[15-k] : logic'(p[0]);
      if (k >= 0 && k < 16) expw[15-k] = d;
      send_bit(chan, w, d, gappy ? (2 + (p % 4) * 5) : 4);
    end
  endtask

  task automatic send_frame(input logic [15:0] l, input logic [15:0] r, input int nbits,
                            input int wpos, input string tag);
    logic [15:0] el;
    logic [15:0] er;
    send_slot(1'b1, l, nbits, wpos, el);
    send_slot(1'b0, r, nbits, wpos, er);
    exp_q.push_back({el, er});
    tag_q.push_back(tag);
  endtask

  task automatic start_group(input logic [1:0] m, input logic p, input logic prime_lr);
    @(negedge clk);
    rst = 1'b1; mode = m; pol = p; bclk = p; lr = prime_lr; wclk = 1'b0; din = 1'b0;
    exp_q.delete(); tag_q.delete();
    repeat (6) @(negedge clk);
    rst = 1'b0;
    send_bit(prime_lr, 1'b0, 1'b0, 4);
    send_bit(prime_lr, 1'b0, 1'b0, 4);
  endtask

  task automatic end_group(input string tag);
    send_bit(1'b1, mode == 2'b11, 1'b0, 4);
    send_bit(1'b1, 1'b0, 1'b0, 4);
    repeat (30) @(negedge clk);
    check(exp_q.size() == 0, tag, exp_q.size(), 32'h0);
  endtask

  initial begin
    logic [15:0] junk;
    // R1: reset state
    start_group(2'b00, 1'b0, 1'b0);
    check(valid_o == 1'b0 && left_o == 16'h0 && right_o == 16'h0, "R1 reset outputs",
          {left_o, right_o}, 32'h0);

    // R2 / R8 / R9: left-justified, 32-bit slots with junk after bit 16
    send_frame(16'h8001, 16'h7FFE, 32, 0, "R2 R8 R9 fmt00 pair a");
    send_frame(16'h1234, 16'hFEDC, 32, 0, "R2 R8 R9 fmt00 pair b");
    end_group("R9 fmt00 pair count");

    // R6: falling-edge sampling
    start_group(2'b00, 1'b1, 1'b0);
    send_frame(16'hA5C3, 16'h3C5A, 32, 0, "R6 falling edge pair a");
    send_frame(16'h0F0F, 16'hF0F0, 32, 0, "R6 falling edge pair b");
    end_group("R6 pair count");

    // R3: one-bit delayed MSB
    start_group(2'b01, 1'b0, 1'b0);
    send_frame(16'hC001, 16'h4002, 32, 0, "R3 delayed msb pair a");
    send_frame(16'h5555, 16'hAAAA, 32, 0, "R3 delayed msb pair b");
    end_group("R3 pair count");

    // R4: right-justified, MSB 16 bit clocks after the change
    start_group(2'b10, 1'b0, 1'b0);
    send_frame(16'h9ABC, 16'h1357, 32, 0, "R4 right-justified pair a");
    send_frame(16'hFFFF, 16'h0001, 32, 0, "R4 right-justified pair b");
    end_group("R4 pair count");

    // R5: word-clock framing, aligned and offset from the frame clock
    start_group(2'b11, 1'b1, 1'b0);
    send_frame(16'h6D2B, 16'hB4D2, 32, 0, "R5 word clock aligned");
    send_frame(16'h2468, 16'h8642, 32, 2, "R5 word clock offset");
    end_group("R5 pair count");

    // R7: short slots zero-fill the low bits
    start_group(2'b00, 1'b0, 1'b0);
    send_frame(16'hFFFF, 16'hABCD, 12, 0, "R7 12-bit zero fill");
    send_frame(16'hBFFF, 16'h7FFF, 4, 0, "R7 4-bit zero fill");
    end_group("R7 pair count");

    // R10: uneven, paused bit clock
    gappy = 1'b1;
    start_group(2'b01, 1'b0, 1'b0);
    send_frame(16'hDEAD, 16'hBEEF, 20, 0, "R10 gated clock pair a");
    send_frame(16'h0123, 16'h4567, 20, 0, "R10 gated clock pair b");
    end_group("R10 pair count");
    gappy = 1'b0;

    // R11: right slot with no stored left word gives nothing
    start_group(2'b00, 1'b0, 1'b1);
    send_slot(1'b0, 16'h7777, 32, 0, junk);
    send_frame(16'h1111, 16'h2222, 32, 0, "R11 first full pair after orphan right");
    end_group("R11 orphan right dropped");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule